// File: doc/BRIEF.md
# Paged Receive Ring Manager

This block places incoming frames into a circular receive area of local memory. The area is split into 256-byte pages, and two configuration inputs give its first page and the page just past its last one. A receive path feeds the block one byte per beat. Each beat carries start and end markers, and the end beat also carries error flags. The block turns every byte into a byte-wide memory write. Each frame begins on a fresh page, and its first four bytes are left free. When the frame ends, the block decides what to do with it. An accepted frame is committed: two header words are written into those four reserved bytes, and the current-page register moves to the first free page after the frame. A rejected frame or an overflowing frame leaves the current-page register where it was, so every page the frame touched is given back.

The host controls a boundary page, which marks where unread data begins, and the write side may never reach it. The host can also load the current page while the block is idle. A sticky overflow flag records any frame lost because the ring was full. A one-cycle commit pulse marks each frame that was stored.

Top module: `rxr_ring`

## Requirements
- R1: While reset is held, `cur_page` takes the value of `cfg_start_page`. `mem_we`, `ovf_flag` and `commit_pulse` are all low.
- R2: The first byte of a frame is written to byte address `{cur_page, 8'h04}`. Later bytes go to consecutive addresses. Each byte write appears one cycle after its beat. It drives the byte on both lanes of `mem_wdata`, with `mem_be` = 2'b01 for an even address and 2'b10 for an odd address.
- R3: After the byte at page offset 8'hFF, writing continues at offset 0 of the next page. The page after `cfg_stop_page`-1 is `cfg_start_page`.
- R4: Suppose the next page a frame needs mid-frame equals `bnd_page`. The block then writes no further bytes of that frame and discards the rest of it. `cur_page` is left unchanged and `ovf_flag` is set. The flag stays set until a cycle in which `ovf_clr` is high and no new overflow occurs.
- R5: For an accepted frame, two full-width writes (`mem_be` = 2'b11) follow the last data byte in the next two cycles. Word 0 goes to `{cur_page, 8'h00}` and word 1 goes to `{cur_page, 8'h02}`.
- R6: Header word 0 holds the next-frame page in bits 15:8, zero in bits 7:6, then bits 5..0 = group-address (bit 0 of the first byte), runt, MII error, alignment error, CRC error, good. Good means none of the four error flags was set.
- R7: Header word 1 holds the number of bytes received, CRC bytes included, in bits 10:0, with bits 15:11 zero. The count saturates at 2047.
- R8: A frame whose end beat carries runt, CRC error or alignment error is rejected. No header is written, no commit pulse occurs, and `cur_page` is unchanged, so the next frame reuses the same pages.
- R9: With `cfg_accept_runt` high, runt frames are not rejected. With `cfg_accept_err` high, CRC and alignment errors are not rejected. Such frames are committed with their error bits set. An MII error alone never causes rejection.
- R10: `commit_pulse` is high for exactly one cycle, the cycle in which header word 1 is presented. `cur_page` takes the next-frame page in that same cycle.
- R11: A `cur_wr_en` pulse loads `cur_wr_data` into `cur_page` one cycle later when the block is idle. A pulse during a frame is ignored.
- R12: Suppose an accepted frame's next-frame page (the page after its last written byte's page) equals `bnd_page`. The frame is then handled as an overflow: no header is written, `cur_page` is unchanged, and `ovf_flag` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start_page | input | 8 | First page of the ring |
| cfg_stop_page | input | 8 | Page just past the ring |
| cfg_accept_runt | input | 1 | Keep runt frames |
| cfg_accept_err | input | 1 | Keep CRC/alignment-error frames |
| bnd_page | input | 8 | Host boundary page |
| cur_wr_en | input | 1 | Host load of current page |
| cur_wr_data | input | 8 | Value for host load |
| ovf_clr | input | 1 | Clears the overflow flag |
| rx_valid | input | 1 | Byte beat valid |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_data | input | 8 | Frame byte |
| rx_runt | input | 1 | Runt flag, sampled at end beat |
| rx_crc_err | input | 1 | CRC error flag, sampled at end beat |
| rx_align_err | input | 1 | Alignment error flag, sampled at end beat |
| rx_mii_err | input | 1 | MII error flag, sampled at end beat |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_be | output | 2 | Byte lane strobes |
| cur_page | output | 8 | Current page register |
| ovf_flag | output | 1 | Sticky overflow flag |
| commit_pulse | output | 1 | Frame committed |

## Verification
The assertions assume a sane configuration: the start page is below the stop page, and the boundary page lies inside the ring. Under that assumption every write address falls within the ring. They also assume that no new frame begins during the two header cycles, and that the host does not load the current page outside the ring. The stimulus keeps the configuration fixed within a frame. It places the boundary and any host-loaded page inside [0x40, 0x60), and it leaves at least five idle cycles between frames.

// File: rtl/rxr_pkg.sv
// Shared types for the paged receive ring manager.
// Assumes nothing beyond the parameters of the modules that import it.
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_DROP,
        ST_HDR0,
        ST_HDR1
    } rxr_state_e;

    // Status bits of header word 0, high to low.
    typedef struct packed {
        logic grp;
        logic runt;
        logic mii;
        logic align;
        logic crc;
        logic good;
    } rxr_stat_t;

endpackage

// File: rtl/rxr_page_step.sv
// Computes the ring successor of a page: the next page number,
// folded back to the first page when it reaches the stop page.
// Assumes first < stop and pg inside [first, stop).
module rxr_page_step #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] pg,
    input  logic [PW-1:0] first,
    input  logic [PW-1:0] stop,
    output logic [PW-1:0] nxt
);
    logic [PW-1:0] inc;

    // Increment and fold at the stop page.
    always_comb begin
        inc = pg + PW'(1);
        nxt = (inc == stop) ? first : inc;
    end
endmodule

// File: rtl/rxr_hdr_fmt.sv
// Packs the two header words written in front of a committed frame.
// Assumes DW equals PW + 8 and CW fits within DW.
module rxr_hdr_fmt
    import rxr_pkg::*;
#(
    parameter int PW = 8,
    parameter int CW = 11,
    parameter int DW = 16
) (
    input  logic [PW-1:0] next_pg,
    input  rxr_stat_t     stat,
    input  logic [CW-1:0] cnt,
    output logic [DW-1:0] word0,
    output logic [DW-1:0] word1
);
    // Word 0: next page, two zero bits, status; word 1: zero-padded count.
    always_comb begin
        word0 = DW'({next_pg, 2'b00, stat});
        word1 = {{(DW-CW){1'b0}}, cnt};
    end
endmodule

// File: rtl/rxr_ring.sv
// Paged receive ring manager. Writes a byte stream into 256-byte pages
// (offset width OW) of a circular area, and reserves four bytes at the
// start of each frame for a header. It commits accepted frames by writing
// the header, and gives back pages of rejected or overflowing frames.
// Assumes: at least two idle beats after each end beat, flags valid on
// the end beat, cfg_start_page < cfg_stop_page, bnd_page inside the ring.
module rxr_ring
    import rxr_pkg::*;
#(
    parameter int PW = 8,
    parameter int OW = 8,
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] cfg_start_page,
    input  logic [PW-1:0] cfg_stop_page,
    input  logic          cfg_accept_runt,
    input  logic          cfg_accept_err,
    input  logic [PW-1:0] bnd_page,
    input  logic          cur_wr_en,
    input  logic [PW-1:0] cur_wr_data,
    input  logic          ovf_clr,
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  logic [7:0]    rx_data,
    input  logic          rx_runt,
    input  logic          rx_crc_err,
    input  logic          rx_align_err,
    input  logic          rx_mii_err,
    output logic          mem_we,
    output logic [PW+OW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    output logic [1:0]    mem_be,
    output logic [PW-1:0] cur_page,
    output logic          ovf_flag,
    output logic          commit_pulse
);
    localparam int AW = PW + OW;
    localparam int DW = 16;
    localparam int HDR_BYTES = 4;
    localparam logic [CW-1:0] CNT_MAX = '1;

    rxr_state_e    state;
    logic [PW-1:0] wr_page;
    logic [OW-1:0] wr_off;
    logic [CW-1:0] cnt;
    logic          grp_q;
    rxr_stat_t     stat_q;
    logic [PW-1:0] scratch_pg;
    logic [PW-1:0] cur_q;
    logic          ovf_q;
    logic          commit_q;
    logic          we_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [1:0]    be_q;

    logic          is_first, is_body, need_adv, adv_block, do_write, eof_hit;
    logic          reject, end_full, commit_go, ovf_evt;
    logic [PW-1:0] adv_pg, wpage, end_pg;
    logic [OW-1:0] woff;
    logic [CW-1:0] cnt_nx;
    rxr_stat_t     stat_nx;
    logic [DW-1:0] hdr_w0, hdr_w1;

    rxr_page_step #(.PW(PW)) u_step_adv (
        .pg(wr_page), .first(cfg_start_page), .stop(cfg_stop_page), .nxt(adv_pg)
    );

    rxr_page_step #(.PW(PW)) u_step_end (
        .pg(wpage), .first(cfg_start_page), .stop(cfg_stop_page), .nxt(end_pg)
    );

    rxr_hdr_fmt #(.PW(PW), .CW(CW), .DW(DW)) u_hdr (
        .next_pg(scratch_pg), .stat(stat_q), .cnt(cnt), .word0(hdr_w0), .word1(hdr_w1)
    );

    // Decode the current beat: target address, page advance, end verdict.
    always_comb begin
        is_first  = (state == ST_IDLE) && rx_valid && rx_sof;
        is_body   = (state == ST_RECV) && rx_valid;
        need_adv  = is_body && (wr_off == '0);
        adv_block = need_adv && (adv_pg == bnd_page);
        wpage     = is_first ? cur_q : (need_adv ? adv_pg : wr_page);
        woff      = is_first ? OW'(HDR_BYTES) : wr_off;
        do_write  = (is_first || is_body) && !adv_block;
        eof_hit   = do_write && rx_eof;
        cnt_nx    = is_first ? CW'(1) : ((cnt == CNT_MAX) ? cnt : cnt + CW'(1));
        reject    = (rx_runt && !cfg_accept_runt) ||
                    ((rx_crc_err || rx_align_err) && !cfg_accept_err);
        end_full  = (end_pg == bnd_page);
        commit_go = eof_hit && !reject && !end_full;
        ovf_evt   = adv_block || (eof_hit && !reject && end_full);
        stat_nx.grp   = is_first ? rx_data[0] : grp_q;
        stat_nx.runt  = rx_runt;
        stat_nx.mii   = rx_mii_err;
        stat_nx.align = rx_align_err;
        stat_nx.crc   = rx_crc_err;
        stat_nx.good  = !(rx_runt || rx_mii_err || rx_align_err || rx_crc_err);
    end

    // Frame sequencing: write pointer, byte count and state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            wr_page    <= '0;
            wr_off     <= '0;
            cnt        <= '0;
            grp_q      <= 1'b0;
            stat_q     <= '0;
            scratch_pg <= '0;
        end else begin
            if (is_first)
                grp_q <= rx_data[0];
            if (do_write) begin
                wr_page <= wpage;
                wr_off  <= woff + OW'(1);
                cnt     <= cnt_nx;
            end
            if (commit_go) begin
                scratch_pg <= end_pg;
                stat_q     <= stat_nx;
            end
            case (state)
                ST_IDLE, ST_RECV: begin
                    if (adv_block)
                        state <= rx_eof ? ST_IDLE : ST_DROP;
                    else if (eof_hit)
                        state <= commit_go ? ST_HDR0 : ST_IDLE;
                    else if (do_write)
                        state <= ST_RECV;
                end
                ST_DROP: if (rx_valid && rx_eof) state <= ST_IDLE;
                ST_HDR0: state <= ST_HDR1;
                ST_HDR1: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory request register: data bytes, then the two header words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else begin
            we_q <= 1'b0;
            if (do_write) begin
                we_q    <= 1'b1;
                addr_q  <= {wpage, woff};
                wdata_q <= {rx_data, rx_data};
                be_q    <= woff[0] ? 2'b10 : 2'b01;
            end else if (state == ST_HDR0) begin
                we_q    <= 1'b1;
                addr_q  <= {cur_q, {OW{1'b0}}};
                wdata_q <= hdr_w0;
                be_q    <= 2'b11;
            end else if (state == ST_HDR1) begin
                we_q    <= 1'b1;
                addr_q  <= {cur_q, OW'(2)};
                wdata_q <= hdr_w1;
                be_q    <= 2'b11;
            end
        end
    end

    // Host-visible registers: current page, sticky overflow, commit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= cfg_start_page;
            ovf_q    <= 1'b0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= (state == ST_HDR1);
            if (state == ST_HDR1)
                cur_q <= scratch_pg;
            else if (cur_wr_en && state == ST_IDLE && !is_first)
                cur_q <= cur_wr_data;
            if (ovf_evt)
                ovf_q <= 1'b1;
            else if (ovf_clr)
                ovf_q <= 1'b0;
        end
    end

    assign mem_we       = we_q;
    assign mem_addr     = addr_q;
    assign mem_wdata    = wdata_q;
    assign mem_be       = be_q;
    assign cur_page     = cur_q;
    assign ovf_flag     = ovf_q;
    assign commit_pulse = commit_q;
endmodule

// File: rtl/rxr_ring_chk.sv
// Property checker for rxr_ring, attached by bind. Observes ports only.
// Assumes a sane ring configuration and host loads inside the ring.
module rxr_ring_chk #(
    parameter int PW = 8,
    parameter int OW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW-1:0] cfg_start_page,
    input logic [PW-1:0] cfg_stop_page,
    input logic          cur_wr_en,
    input logic          ovf_clr,
    input logic          mem_we,
    input logic [PW+OW-1:0] mem_addr,
    input logic [1:0]    mem_be,
    input logic [PW-1:0] cur_page,
    input logic          ovf_flag,
    input logic          commit_pulse
);
    // Byte writes use a single lane matching the address parity.
    p_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be != 2'b11) |-> ($countones(mem_be) == 1 && mem_be[1] == mem_addr[0]));

    // Every write lands inside the ring.
    p_in_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[PW+OW-1:OW] >= cfg_start_page && mem_addr[PW+OW-1:OW] < cfg_stop_page));

    // Overflow flag holds until cleared.
    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // Current page moves only on a commit or a host load.
    p_cur_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_wr_en ##1 !commit_pulse) |-> $stable(cur_page));

    // Commit coincides with the second header word.
    p_commit_hdr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |-> (mem_we && mem_be == 2'b11 && mem_addr[OW-1:0] == OW'(2)));

    // Commit lasts a single cycle.
    p_commit_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |=> !commit_pulse);
endmodule

bind rxr_ring rxr_ring_chk #(.PW(PW), .OW(OW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_start_page(cfg_start_page),
    .cfg_stop_page(cfg_stop_page), .cur_wr_en(cur_wr_en), .ovf_clr(ovf_clr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .cur_page(cur_page),
    .ovf_flag(ovf_flag), .commit_pulse(commit_pulse)
);

// File: tb/sim_rxr_ring.sv
`timescale 1ns/1ps
module sim_rxr_ring;
    localparam logic [7:0] START = 8'h40;
    localparam logic [7:0] STOP  = 8'h60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] cfg_start_page = START, cfg_stop_page = STOP;
    logic cfg_accept_runt = 1'b0, cfg_accept_err = 1'b0;
    logic [7:0] bnd_page = 8'h5F;
    logic cur_wr_en = 1'b0;
    logic [7:0] cur_wr_data = '0;
    logic ovf_clr = 1'b0;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0] rx_data = '0;
    logic rx_runt = 1'b0, rx_crc_err = 1'b0, rx_align_err = 1'b0, rx_mii_err = 1'b0;
    logic mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [1:0] mem_be;
    logic [7:0] cur_page;
    logic ovf_flag, commit_pulse;

    int errors = 0;
    int checks = 0;
    int exp_commits = 0;
    int got_commits = 0;
    logic [7:0] m_cur = START;
    logic exp_ovf = 1'b0;
    logic [33:0] exp_q[$];

    always #2 clk = ~clk;

    rxr_ring u0 (
        .clk(clk), .rst_n(rst_n), .cfg_start_page(cfg_start_page),
        .cfg_stop_page(cfg_stop_page), .cfg_accept_runt(cfg_accept_runt),
        .cfg_accept_err(cfg_accept_err), .bnd_page(bnd_page), .cur_wr_en(cur_wr_en),
        .cur_wr_data(cur_wr_data), .ovf_clr(ovf_clr), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data), .rx_runt(rx_runt),
        .rx_crc_err(rx_crc_err), .rx_align_err(rx_align_err), .rx_mii_err(rx_mii_err),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .cur_page(cur_page), .ovf_flag(ovf_flag), .commit_pulse(commit_pulse)
    );

    task automatic check(input bit ok, input string req, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] succ(input logic [7:0] p);
        return (p + 8'd1 == STOP) ? START : p + 8'd1;
    endfunction

    // Monitor: pop expected writes and count commit pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (exp_q.size() == 0)
                    check(1'b0, "R2/R5 unexpected write", {mem_addr, mem_be, mem_wdata}, '0);
                else begin
                    logic [33:0] e;
                    e = exp_q.pop_front();
                    check({mem_addr, mem_be, mem_wdata} == e, "R2/R3/R5/R6/R7 write",
                          {mem_addr, mem_be, mem_wdata}, e);
                end
            end
            if (commit_pulse) got_commits++;
        end
    end

    // Driver: build the expected writes for a frame, then stream it.
    task automatic send_frame(input int n, input bit mc, input bit runt, input bit crc,
                              input bit align, input bit mii, input logic [7:0] seed,
                              input int poke_at);
        logic [7:0] page;
        int off;
        bit ovf;
        bit rej;
        logic [7:0] np;
        logic [7:0] d;
        page = m_cur;
        off = 4;
        ovf = 0;
        for (int i = 0; i < n; i++) begin
            if (i > 0 && off == 256) begin
                np = succ(page);
                if (np == bnd_page) begin ovf = 1; break; end
                page = np;
                off = 0;
            end
            d = (i == 0) ? {seed[6:0], mc} : 8'(seed + i * 13);
            exp_q.push_back({page, 8'(off), (off % 2 == 1) ? 2'b10 : 2'b01, d, d});
            off++;
        end
        if (!ovf) begin
            rej = (runt && !cfg_accept_runt) || ((crc || align) && !cfg_accept_err);
            if (!rej) begin
                np = succ(page);
                if (np == bnd_page) ovf = 1;
                else begin
                    exp_q.push_back({m_cur, 8'h00, 2'b11, np, 2'b00, mc, runt, mii, align, crc,
                                     !(runt | crc | align | mii)});
                    exp_q.push_back({m_cur, 8'h02, 2'b11, 5'd0, (n > 2047) ? 11'd2047 : 11'(n)});
                    m_cur = np;
                    exp_commits++;
                end
            end
        end
        if (ovf) exp_ovf = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof = (i == 0);
            rx_eof = (i == n - 1);
            rx_data = (i == 0) ? {seed[6:0], mc} : 8'(seed + i * 13);
            rx_runt = runt; rx_crc_err = crc; rx_align_err = align; rx_mii_err = mii;
            cur_wr_en = (i == poke_at);
            cur_wr_data = 8'h77;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; cur_wr_en = 1'b0;
        rx_runt = 0; rx_crc_err = 0; rx_align_err = 0; rx_mii_err = 0;
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R4/R5/R8 missing writes", 34'(exp_q.size()), 0);
        check(cur_page == m_cur, "R8/R10/R11 cur_page", 34'(cur_page), 34'(m_cur));
        check(got_commits == exp_commits, "R10 commit count", 34'(got_commits), 34'(exp_commits));
        check(ovf_flag == exp_ovf, "R4/R12 ovf_flag", 34'(ovf_flag), 34'(exp_ovf));
    endtask

    task automatic host_load(input logic [7:0] v);
        @(negedge clk); cur_wr_en = 1'b1; cur_wr_data = v;
        @(negedge clk); cur_wr_en = 1'b0;
        m_cur = v;
        check(cur_page == v, "R11 idle load", 34'(cur_page), 34'(v));
    endtask

    task automatic clear_ovf();
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        exp_ovf = 1'b0;
        check(ovf_flag == 1'b0, "R4 ovf clear", 34'(ovf_flag), 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cur_page == START, "R1 cur_page", 34'(cur_page), 34'(START));
        check(!mem_we && !ovf_flag && !commit_pulse, "R1 outputs idle",
              {mem_we, ovf_flag, commit_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        send_frame(60, 1, 0, 0, 0, 0, 8'h11, -1);   // R2 R5 R6 R7 R10 short frame
        send_frame(600, 0, 0, 0, 0, 0, 8'h22, -1);  // R3 multi-page
        send_frame(252, 1, 0, 0, 0, 0, 8'h33, -1);  // R3 exact page fill
        send_frame(300, 0, 0, 1, 0, 0, 8'h44, -1);  // R8 CRC reject
        send_frame(100, 0, 0, 0, 0, 0, 8'h55, -1);  // R8 pages reused
        send_frame(40, 0, 1, 0, 0, 0, 8'h66, -1);   // R8 runt reject
        send_frame(70, 1, 0, 0, 1, 0, 8'h77, -1);   // R8 alignment reject
        cfg_accept_err = 1'b1;
        send_frame(90, 0, 0, 1, 1, 0, 8'h88, -1);   // R9 errored frame kept
        cfg_accept_err = 1'b0;
        cfg_accept_runt = 1'b1;
        send_frame(30, 1, 1, 0, 0, 0, 8'h99, -1);   // R9 runt kept
        cfg_accept_runt = 1'b0;
        send_frame(80, 0, 0, 0, 0, 1, 8'hA1, -1);   // R9 MII error alone kept
        send_frame(2100, 0, 0, 0, 0, 0, 8'hB2, -1); // R7 count saturation
        host_load(8'h5E);                           // R11 idle load
        bnd_page = 8'h50;
        send_frame(600, 1, 0, 0, 0, 0, 8'hC3, 10);  // R3 wrap, R11 load ignored mid-frame
        bnd_page = 8'h43;
        send_frame(700, 0, 0, 0, 0, 0, 8'hD4, -1);  // R4 mid-frame overflow
        send_frame(50, 0, 0, 0, 0, 0, 8'hE5, -1);   // R4 flag stays set
        clear_ovf();
        send_frame(100, 1, 0, 0, 0, 0, 8'hF6, -1);  // R12 end-page overflow
        clear_ovf();
        finish_run();
    end
endmodule